// File: doc/BRIEF.md
# Clear-to-Send Monitor and Loop-Control Pin Driver

This block owns a single active-low pin of one serial channel and gives it two roles. In normal operation the pin is an input: its level passes through a synchronizer, can optionally hold off the transmitter while the far end has not granted clear-to-send, and any change of level sets a sticky flag that can raise an interrupt. Software reads the synchronized level and the flag, and clears the flag with a one-cycle strobe.

In bit-oriented loop mode the same pin turns into an active-low output. A loop-control latch drives it. That latch changes only when software issues an explicit assert or negate command. While the block is in this mode it ignores the input side. No change events are logged and the transmitter is not gated. Toggling the loop-control output touches nothing but the pin level, so an external loop interface can go on-line or off-line without disturbing the channel.

Top module: `cts_loop_ctl`

## Requirements
- R1: After reset, pin_oe=0, pin_out=1, tx_enable=0, stat_cts=0, stat_change=0 and irq=0.
- R2: Outside loop mode, tx_enable equals tx_req when cts_gate_en=0. When cts_gate_en=1 it equals tx_req ANDed with stat_cts.
- R3: stat_cts is 1 when the synchronized pin is low. A change on pin_in appears on stat_cts at the second rising clock edge after it, and never at the first.
- R4: Outside loop mode, both a falling and a rising change of the synchronized level set stat_change. This happens one clock edge after stat_cts changes.
- R5: irq is 1 exactly when stat_change=1 and irq_en=1, with no added clock delay.
- R6: A one-cycle chg_clr pulse clears stat_change at the next rising edge, and stat_change then stays 0 until a new level change.
- R7: When a new level change and chg_clr fall in the same cycle, stat_change is 1 after that edge.
- R8: In loop mode, tx_enable equals tx_req whatever the pin level and cts_gate_en.
- R9: In loop mode, pin level changes never set stat_change. A level change that happened during loop mode does not set stat_change after loop mode ends.
- R10: In loop mode pin_oe=1 and pin_out is 0 while the loop-control latch is asserted. cmd_lc_on asserts the latch at the next edge and cmd_lc_off negates it. When both are issued in the same cycle, negate wins.
- R11: Outside loop mode pin_oe=0 and pin_out=1. Loop-control commands issued there are ignored, and the latch keeps its state for the next entry into loop mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pin_in | input | 1 | Level sensed on the pin (low = clear to send) |
| pin_out | output | 1 | Level driven onto the pin (low = loop control asserted) |
| pin_oe | output | 1 | Output enable for the pin, high in loop mode |
| loop_mode | input | 1 | Selects bit-oriented loop mode |
| cmd_lc_on | input | 1 | Command strobe: assert loop control |
| cmd_lc_off | input | 1 | Command strobe: negate loop control |
| cts_gate_en | input | 1 | Lets clear-to-send gate the transmitter |
| tx_req | input | 1 | Transmitter enable requested by the channel |
| tx_enable | output | 1 | Gated transmitter enable |
| stat_cts | output | 1 | Synchronized clear-to-send, 1 = pin low |
| stat_change | output | 1 | Sticky level-change flag |
| irq_en | input | 1 | Interrupt enable for the change flag |
| irq | output | 1 | Interrupt request, active high |
| chg_clr | input | 1 | Strobe that clears the change flag |

## Verification
Two functions can land on the same edge: the flag clear strobe and the recording of a fresh level change. The bench first leaves the flag set. It then changes the pin so that the edge detector fires exactly in the cycle where chg_clr is high, and expects the flag to read 1 after that edge. A separate clear with no change then shows the flag drops. The second collision is a cycle carrying both loop commands, where the pin must end negated.

// File: rtl/cts_loop_ctl.sv
module cts_loop_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_in,
  output logic pin_out,
  output logic pin_oe,
  input  logic loop_mode,
  input  logic cmd_lc_on,
  input  logic cmd_lc_off,
  input  logic cts_gate_en,
  input  logic tx_req,
  output logic tx_enable,
  output logic stat_cts,
  output logic stat_change,
  input  logic irq_en,
  output logic irq,
  input  logic chg_clr
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [LAST:0] sync_q;
  logic          prev_q;
  logic          chg_q;
  logic          lc_q;
  logic          lvl;
  logic          level_moved;

  assign lvl         = sync_q[LAST];
  assign level_moved = (lvl != prev_q) && !loop_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '1;
      prev_q <= 1'b1;
    end else begin
      sync_q <= {sync_q[LAST-1:0], pin_in};
      prev_q <= lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      chg_q <= 1'b0;
    else if (level_moved)
      chg_q <= 1'b1;
    else if (chg_clr)
      chg_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lc_q <= 1'b0;
    else if (loop_mode) begin
      if (cmd_lc_off)
        lc_q <= 1'b0;
      else if (cmd_lc_on)
        lc_q <= 1'b1;
    end
  end

  assign stat_cts    = ~lvl;
  assign stat_change = chg_q;
  assign irq         = chg_q & irq_en;
  assign tx_enable   = tx_req & (loop_mode | ~cts_gate_en | ~lvl);
  assign pin_oe      = loop_mode;
  assign pin_out     = ~(loop_mode & lc_q);

endmodule

module cts_loop_ctl_chk (
  input logic clk,
  input logic rst_n,
  input logic pin_out,
  input logic pin_oe,
  input logic loop_mode,
  input logic cmd_lc_on,
  input logic cmd_lc_off,
  input logic tx_req,
  input logic tx_enable,
  input logic stat_change,
  input logic irq_en,
  input logic irq,
  input logic chg_clr
);

  AST_TX_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    tx_enable |-> tx_req);  // R2

  AST_LOOP_TX_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && tx_req) |-> tx_enable);  // R8

  AST_IRQ_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (stat_change && irq_en));  // R5

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_change && !chg_clr) |=> stat_change);  // R6

  AST_LOOP_NO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && !stat_change) |=> !stat_change);  // R9

  AST_LC_ASSERT: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && cmd_lc_on && !cmd_lc_off) ##1 loop_mode |-> !pin_out);  // R10

  AST_LC_NEGATE: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_mode && cmd_lc_off) |=> pin_out);  // R10

  AST_PIN_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !pin_oe |-> pin_out);  // R11

endmodule

bind cts_loop_ctl cts_loop_ctl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pin_out(pin_out), .pin_oe(pin_oe),
  .loop_mode(loop_mode), .cmd_lc_on(cmd_lc_on), .cmd_lc_off(cmd_lc_off),
  .tx_req(tx_req), .tx_enable(tx_enable), .stat_change(stat_change),
  .irq_en(irq_en), .irq(irq), .chg_clr(chg_clr)
);

// File: tb/cts_loop_ctl_test.sv
module cts_loop_ctl_test;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pin_in = 1'b1, loop_mode = 1'b0, cmd_lc_on = 1'b0, cmd_lc_off = 1'b0;
  logic cts_gate_en = 1'b1, tx_req = 1'b0, irq_en = 1'b0, chg_clr = 1'b0;
  logic pin_out, pin_oe, tx_enable, stat_cts, stat_change, irq;

  always #5 clk = ~clk;

  cts_loop_ctl uut (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .loop_mode(loop_mode), .cmd_lc_on(cmd_lc_on), .cmd_lc_off(cmd_lc_off),
    .cts_gate_en(cts_gate_en), .tx_req(tx_req), .tx_enable(tx_enable),
    .stat_cts(stat_cts), .stat_change(stat_change), .irq_en(irq_en),
    .irq(irq), .chg_clr(chg_clr)
  );

  // observed vector: [5]pin_oe [4]pin_out [3]tx_enable [2]stat_cts [1]stat_change [0]irq
  typedef struct {
    int         cyc;
    logic [5:0] mask;
    logic [5:0] val;
    string      req;
  } exp_t;

  exp_t sb[$];
  int cyc = 0;
  int total = 0;
  int bad = 0;
  bit done = 0;

  task automatic expect_at(input int d, input logic [5:0] mask, input logic [5:0] val,
                           input string req);
    exp_t e;
    e.cyc = cyc + d; e.mask = mask; e.val = val; e.req = req;
    sb.push_back(e);
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  always @(posedge clk) begin
    logic [5:0] obs;
    cyc++;
    #3;
    obs = {pin_oe, pin_out, tx_enable, stat_cts, stat_change, irq};
    while (sb.size() > 0 && sb[0].cyc <= cyc) begin
      exp_t e;
      e = sb.pop_front();
      total++;
      if ((obs & e.mask) !== (e.val & e.mask)) begin
        bad++;
        $display("FAIL %s cyc=%0d actual=%b expected=%b mask=%b",
                 e.req, cyc, obs, e.val, e.mask);
      end
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    @(negedge clk);
    expect_at(1, 6'b111111, 6'b010000, "R1");
    wait_cyc(2);

    tx_req = 1'b1;
    expect_at(1, 6'b001000, 6'b000000, "R2");
    wait_cyc(2);

    pin_in = 1'b0;
    expect_at(1, 6'b000100, 6'b000000, "R3");
    expect_at(2, 6'b001100, 6'b001100, "R3");
    expect_at(3, 6'b000011, 6'b000010, "R4");
    wait_cyc(4);

    irq_en = 1'b1;
    expect_at(1, 6'b000011, 6'b000011, "R5");
    wait_cyc(1);
    chg_clr = 1'b1;
    expect_at(1, 6'b000011, 6'b000000, "R6");
    wait_cyc(1);
    chg_clr = 1'b0;
    expect_at(3, 6'b000010, 6'b000000, "R6");
    wait_cyc(4);

    pin_in = 1'b1;
    expect_at(2, 6'b001100, 6'b000000, "R2");
    expect_at(3, 6'b000011, 6'b000011, "R4");
    wait_cyc(4);

    cts_gate_en = 1'b0;
    expect_at(1, 6'b001000, 6'b001000, "R2");
    wait_cyc(2);
    cts_gate_en = 1'b1;
    wait_cyc(1);

    // clear strobe collides with a fresh level change
    pin_in = 1'b0;
    wait_cyc(2);
    chg_clr = 1'b1;
    expect_at(1, 6'b000010, 6'b000010, "R7");
    wait_cyc(1);
    chg_clr = 1'b0;
    wait_cyc(2);
    chg_clr = 1'b1;
    expect_at(1, 6'b000010, 6'b000000, "R7");
    wait_cyc(1);
    chg_clr = 1'b0;

    pin_in = 1'b1;
    wait_cyc(4);
    chg_clr = 1'b1;
    wait_cyc(1);
    chg_clr = 1'b0;
    wait_cyc(1);

    loop_mode = 1'b1;
    expect_at(1, 6'b111000, 6'b111000, "R8");
    wait_cyc(2);
    pin_in = 1'b0;
    expect_at(3, 6'b000011, 6'b000000, "R9");
    expect_at(5, 6'b000010, 6'b000000, "R9");
    wait_cyc(6);

    cmd_lc_on = 1'b1;
    expect_at(1, 6'b110000, 6'b100000, "R10");
    wait_cyc(1);
    cmd_lc_on = 1'b0;
    wait_cyc(1);
    cmd_lc_off = 1'b1;
    expect_at(1, 6'b110000, 6'b110000, "R10");
    wait_cyc(1);
    cmd_lc_off = 1'b0;
    wait_cyc(1);
    cmd_lc_on = 1'b1;
    cmd_lc_off = 1'b1;
    expect_at(1, 6'b110000, 6'b110000, "R10");
    wait_cyc(1);
    cmd_lc_off = 1'b0;
    expect_at(1, 6'b110000, 6'b100000, "R10");
    wait_cyc(1);
    cmd_lc_on = 1'b0;
    wait_cyc(1);

    loop_mode = 1'b0;
    expect_at(1, 6'b110000, 6'b010000, "R11");
    expect_at(3, 6'b000010, 6'b000000, "R9");
    wait_cyc(4);
    cmd_lc_off = 1'b1;
    wait_cyc(1);
    cmd_lc_off = 1'b0;
    expect_at(1, 6'b110000, 6'b010000, "R11");
    wait_cyc(2);
    loop_mode = 1'b1;
    expect_at(1, 6'b110000, 6'b100000, "R11");
    wait_cyc(3);

    done = 1;
  end

  initial begin
    for (int i = 0; i < 5000 && !done; i++) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
    end
    if (sb.size() != 0) begin
      total++;
      bad++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", sb.size());
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule